// File: doc/BRIEF.md
# Local Bus Burst Master Sequencer

This block drives the master side of a synchronous local bus. It takes one transfer request (start address, beat count, direction) and turns it into a series of data beats. Each beat carries an address on `la`. A beat that opens a new address phase has `ads_n` low, and a beat that closes a burst has `blast_n` low. A beat is complete on the clock where the slave drives `ready_n` low, and that clock is reported on `beat_stb`. The slave stretches a beat by holding `ready_n` high. The bus may be 8, 16 or 32 bits wide.

Two configuration bits choose how beats are grouped. With `cfg_burst` clear, every beat is a single cycle with its own address strobe. With `cfg_burst` set and `cfg_bterm_en` clear, a burst stops at the end of each aligned group of four bus units. With both bits set, the block keeps streaming from one strobe, and the slave can split the stream by pulling `bterm_n` low. The fill level of the attached FIFO can also end a burst. In that case the sequencer parks until the FIFO can move again, then resumes with a fresh address phase.

The request side follows valid/ready rules. A request is taken on a clock where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the sequencer is idle. The configuration bits and `bus_width` must stay constant from acceptance until the transfer ends.

Top module: `lbus_burst_seq`

## Requirements
- R1: After asynchronous reset the sequencer is idle: `bus_cyc` low, `ads_n` and `blast_n` high, `beat_stb` low and `req_ready` high; `ads_n`/`blast_n` stay high whenever `bus_cyc` is low.
- R2: A request is accepted when `req_valid` and `req_ready` are both high; `req_ready` is low while a transfer is active; a request with `req_len` = 0 is accepted and produces no beat.
- R3: A beat completes only on a clock where `ready_n` is low (`beat_stb` high); while `ready_n` is high, `la` and `ads_n` hold their values into the next cycle.
- R4: `bus_width` code 0 = 8-bit, 1 = 16-bit, 2 = 32-bit; the address advances by 1, 2 or 4 after each completed beat, and the first beat carries `req_addr`.
- R5: With `cfg_burst` = 0, every beat has both `ads_n` and `blast_n` low, whatever `cfg_bterm_en` and `bterm_n` are.
- R6: With `cfg_burst` = 1 and `cfg_bterm_en` = 0, the beat whose address has `(la >> code)[1:0]` = 3 has `blast_n` low, the next beat has `ads_n` low, and `bterm_n` has no effect.
- R7: With `cfg_burst` = 1 and `cfg_bterm_en` = 1, only the first beat has `ads_n` low unless `bterm_n` is low on a completing beat; the following beat then has `ads_n` low at the next address, and `bterm_n` never causes `blast_n`.
- R8: The final beat of a transfer has `blast_n` low; a one-beat transfer has `ads_n` and `blast_n` low on the same beat; after the final beat the sequencer returns to idle.
- R9: The stop flag is `fifo_full` when `req_dir` = 1 (read) and `fifo_empty` when `req_dir` = 0 (write); the other flag is ignored. When the stop flag is high during a beat, `blast_n` is low. After that beat completes, no beat is issued while the flag stays high, and the next beat has `ads_n` low at the next address. A stop flag that is high at acceptance delays the first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_burst | input | 1 | Burst enable |
| cfg_bterm_en | input | 1 | Continuous burst with slave break |
| bus_width | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | AW | Start address |
| req_len | input | LW | Transfer length in beats |
| req_dir | input | 1 | 1 = read (into FIFO), 0 = write (from FIFO) |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| ready_n | input | 1 | Slave beat acknowledge, active low |
| bterm_n | input | 1 | Slave burst break, active low |
| la | output | AW | Local address of the current beat |
| ads_n | output | 1 | Address strobe, active low |
| blast_n | output | 1 | Last beat of burst, active low |
| bus_cyc | output | 1 | A beat is on the bus |
| beat_stb | output | 1 | Data strobe: current beat completes |

## Verification
Some rules are checked on every cycle by the assertions. These are: strobes stay quiet outside a beat, address and strobe are held during wait states, the address step matches the bus width, single-cycle mode marks every beat, a quad-boundary beat ends a four-beat burst, and every burst end is followed by a fresh address strobe. Other behaviour depends on the whole beat sequence, and only the bench scenarios can show it. That covers the exact beat count, the return to idle, zero-length requests, breaks made by `bterm_n` in continuous mode, the parking caused by the FIFO flag, and the proof that the flag for the other direction is ignored. The bench sweeps every mode, width, start offset within a quad and length from 1 to 9, under mixed wait-state, break and FIFO patterns.

// File: rtl/lbus_seq_pkg.sv
package lbus_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;

  // Address increment per completed beat for a width code
  function automatic logic [2:0] step_of(input logic [1:0] code);
    case (code)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

  // Last unit of an aligned group of four bus units
  function automatic logic quad_end(input logic [3:0] a, input logic [1:0] code);
    case (code)
      2'd0:    quad_end = (a[1:0] == 2'b11);
      2'd1:    quad_end = (a[2:1] == 2'b11);
      default: quad_end = (a[3:2] == 2'b11);
    endcase
  endfunction

endpackage

// File: rtl/lbus_addr_gen.sv
module lbus_addr_gen
  import lbus_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  input  logic [1:0]    width,
  output logic [AW-1:0] addr,
  output logic          at_quad_end
);

  logic [AW-1:0] step_w;

  assign step_w      = AW'(step_of(width));
  assign at_quad_end = quad_end(addr[3:0], width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (adv)  addr <= addr + step_w;
  end

endmodule

// File: rtl/lbus_beat_ctr.sv
module lbus_beat_ctr #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_len,
  input  logic          dec,
  output logic          last
);

  logic [LW-1:0] rem_q;

  assign last = (rem_q == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_len;
    else if (dec)  rem_q <= rem_q - LW'(1);
  end

endmodule

// File: rtl/lbus_burst_seq.sv
module lbus_burst_seq
  import lbus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_burst,
  input  logic          cfg_bterm_en,
  input  logic [1:0]    bus_width,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_dir,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  input  logic          ready_n,
  input  logic          bterm_n,
  output logic [AW-1:0] la,
  output logic          ads_n,
  output logic          blast_n,
  output logic          bus_cyc,
  output logic          beat_stb
);

  seq_state_e state_q;
  logic       seg_new_q;
  logic       dir_q;
  logic       accept, start, done, last, qend;
  logic       stop_now, stop_acc, cont_mode, blast_c;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign start     = accept & (req_len != '0);
  assign bus_cyc   = (state_q == ST_RUN);
  assign done      = bus_cyc & ~ready_n;
  assign beat_stb  = done;
  assign cont_mode = cfg_burst & cfg_bterm_en;

  // FIFO limit flag for the active direction
  assign stop_now = dir_q   ? fifo_full : fifo_empty;
  assign stop_acc = req_dir ? fifo_full : fifo_empty;

  assign blast_c = last | ~cfg_burst | (cfg_burst & ~cfg_bterm_en & qend) | stop_now;

  assign ads_n   = ~(bus_cyc & seg_new_q);
  assign blast_n = ~(bus_cyc & blast_c);

  lbus_addr_gen #(.AW(AW)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (start),
    .load_addr   (req_addr),
    .adv         (done),
    .width       (bus_width),
    .addr        (la),
    .at_quad_end (qend)
  );

  lbus_beat_ctr #(.LW(LW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_len (req_len),
    .dec      (done),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      seg_new_q <= 1'b0;
      dir_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            dir_q     <= req_dir;
            seg_new_q <= 1'b1;
            state_q   <= stop_acc ? ST_HOLD : ST_RUN;
          end
        end
        ST_RUN: begin
          if (done) begin
            if (last) begin
              state_q   <= ST_IDLE;
              seg_new_q <= 1'b0;
            end else if (stop_now) begin
              state_q   <= ST_HOLD;
              seg_new_q <= 1'b1;
            end else begin
              // bterm_n is sampled only here, while a beat owns the bus
              seg_new_q <= blast_c | (cont_mode & ~bterm_n);
            end
          end
        end
        ST_HOLD: begin
          if (!stop_now) state_q <= ST_RUN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lbus_burst_seq_chk.sv
module lbus_burst_seq_chk
  import lbus_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_burst,
  input logic          cfg_bterm_en,
  input logic [1:0]    bus_width,
  input logic          ready_n,
  input logic [AW-1:0] la,
  input logic          ads_n,
  input logic          blast_n,
  input logic          bus_cyc,
  input logic          beat_stb
);

  // R1: strobes quiet outside a beat
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> (ads_n && blast_n && !beat_stb));

  // R3: wait state holds address and strobe
  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && ready_n) |=> (bus_cyc && $stable(la) && $stable(ads_n)));

  // R3: no completion without acknowledge
  a_r3_stb_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    beat_stb |-> !ready_n);

  // R4: address step follows bus width
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(beat_stb) && bus_cyc) |->
      (la == $past(la) + AW'(step_of($past(bus_width)))));

  // R5: single-cycle mode marks every beat
  a_r5_single_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !cfg_burst) |-> (!ads_n && !blast_n));

  // R6: quad boundary ends a four-beat burst
  a_r6_quad_blast: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && cfg_burst && !cfg_bterm_en && quad_end(la[3:0], bus_width)) |-> !blast_n);

  // R8/R9: a burst end is followed by a new address phase
  a_r9_blast_then_ads: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(beat_stb && !blast_n) && bus_cyc) |-> !ads_n);

endmodule

bind lbus_burst_seq lbus_burst_seq_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_burst    (cfg_burst),
  .cfg_bterm_en (cfg_bterm_en),
  .bus_width    (bus_width),
  .ready_n      (ready_n),
  .la           (la),
  .ads_n        (ads_n),
  .blast_n      (blast_n),
  .bus_cyc      (bus_cyc),
  .beat_stb     (beat_stb)
);

// File: tb/lbus_burst_seq_test.sv
`timescale 1ns/1ps
module lbus_burst_seq_test;

  localparam int AW = 16;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_burst = 1'b0, cfg_bterm_en = 1'b0;
  logic [1:0]    bus_width = 2'd2;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_dir = 1'b0;
  logic          fifo_full = 1'b1, fifo_empty = 1'b1;
  logic          ready_n = 1'b1, bterm_n = 1'b1;
  logic [AW-1:0] la;
  logic          ads_n, blast_n, bus_cyc, beat_stb;

  int total = 0;
  int bad = 0;
  int k = 0;

  always #2 clk = ~clk;

  lbus_burst_seq #(.AW(AW), .LW(LW)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_flag(input bit dir, input bit stop);
    // flag of the other direction is held high: it must be ignored (R9)
    if (dir) begin fifo_full = stop; fifo_empty = 1'b1; end
    else     begin fifo_empty = stop; fifo_full = 1'b1; end
  endtask

  task automatic run_xfer(input bit burst, input bit bten, input logic [1:0] w,
                          input logic [AW-1:0] a0, input int len, input bit dir);
    int step, rem, guard;
    logic [AW-1:0] ea;
    bit eads, hold, fst, eb, qe;
    step = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    @(negedge clk);
    cfg_burst = burst; cfg_bterm_en = bten; bus_width = w;
    req_addr = a0; req_len = LW'(len); req_dir = dir; req_valid = 1'b1;
    fst = (((k * 7) + 3) % 13) == 0;
    set_flag(dir, fst);
    #1;
    chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    hold = fst; eads = 1'b1; ea = a0; rem = len; guard = 0;
    while (rem > 0 && guard < 400) begin
      guard++; k++;
      fst     = (((k * 7) + 3) % 13) == 0;
      ready_n = (k % 3) == 2;
      bterm_n = (k % 4) != 1;
      set_flag(dir, fst);
      #1;
      chk(req_ready == 1'b0, "R2 busy", req_ready, 0);
      if (hold) begin
        chk(bus_cyc == 1'b0, "R9 parked on FIFO flag", bus_cyc, 0);
        if (!fst) hold = 1'b0;
      end else begin
        case (w)
          2'd0:    qe = (ea[1:0] == 2'b11);
          2'd1:    qe = (ea[2:1] == 2'b11);
          default: qe = (ea[3:2] == 2'b11);
        endcase
        eb = (rem == 1) || !burst || (burst && !bten && qe) || fst;
        chk(bus_cyc == 1'b1, "R3 beat on bus", bus_cyc, 1);
        chk(la == ea, "R4 beat address", la, ea);
        chk(ads_n == !eads, burst ? (bten ? "R7 ads" : "R6 ads") : "R5 ads", ads_n, !eads);
        chk(blast_n == !eb, burst ? (bten ? "R7 blast" : "R6 blast") : "R5 blast", blast_n, !eb);
        chk(beat_stb == !ready_n, "R3 strobe", beat_stb, !ready_n);
        if (!ready_n) begin
          rem--;
          ea = ea + AW'(step);
          if (fst) begin hold = 1'b1; eads = 1'b1; end
          else eads = eb || (burst && bten && !bterm_n);
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    if (guard >= 400) chk(1'b0, "R8 transfer ended", guard, len);
    ready_n = 1'b1; bterm_n = 1'b1;
    #1;
    chk(bus_cyc == 1'b0 && ads_n && blast_n, "R8 idle after last beat", bus_cyc, 0);
    chk(req_ready == 1'b1, "R2 ready after end", req_ready, 1);
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    chk(bus_cyc == 1'b0 && ads_n && blast_n && !beat_stb, "R1 reset quiet", bus_cyc, 0);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    #5 rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cyc == 1'b0 && ads_n && blast_n, "R1 idle after reset", bus_cyc, 0);

    // zero length: accepted, no beat (R2)
    @(negedge clk);
    req_len = '0; req_addr = 16'h0040; req_valid = 1'b1;
    #1 chk(req_ready == 1'b1, "R2 zero-length ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1 chk(bus_cyc == 1'b0 && ads_n, "R2 zero-length no beat", bus_cyc, 0);
      @(negedge clk);
    end

    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 3; w++)
        for (int off = 0; off < 4; off++)
          for (int len = 1; len <= 9; len++) begin
            int stp;
            stp = (w == 0) ? 1 : (w == 1) ? 2 : 4;
            run_xfer(m >= 2, (m == 1) || (m == 3), 2'(w),
                     AW'(16'h1230 + off * stp), len, ((len + off) % 2) == 1);
          end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule